// File: doc/BRIEF.md
# Indexed Colour Palette Access Port

This block gives a processor byte-wide access to a colour palette memory of 64 sixteen-bit entries. The memory is split into two halves. The background half holds entries 0 to 31 and the object half holds entries 32 to 63. Each half has two registers on an 8-bit register bus:

- A **pointer register**, which selects one byte inside its half and carries an auto-advance flag.
- A **data register**, which reads or writes the byte that the pointer selects.

Software loads the pointer once with the flag set. It can then stream a whole half of the palette through repeated data writes. Reads have no side effects. The data register always returns the byte the pointer currently selects, so a new pointer value is visible on the very next access.

Top module: `palette_port`

## Requirements
- R1: After reset, both pointer registers hold a byte index of 0 with auto-advance off, so a pointer read returns 0x40.
- R2: A pointer write loads the byte index from write bits 5:0 and the auto-advance flag from bit 7; bit 6 of the write is ignored. A pointer read returns the flag in bit 7, a constant 1 in bit 6 and the index in bits 5:0.
- R3: A data write stores the byte into entry (index >> 1) of its half. Index bit 0 = 0 selects the low byte (bits 7:0) and index bit 0 = 1 selects the high byte (bits 15:8).
- R4: Register select bus_sel bit 1 picks the half (0 = background, 1 = object) and bit 0 picks pointer (0) or data (1). Object entries lie after the 32 background entries, and writing one half never changes the other half's entries or pointer.
- R5: A data read returns the byte the pointer selects. After a pointer write, the next data read already returns the newly addressed byte.
- R6: A data write with auto-advance set increments the index by one afterwards, wrapping from 63 to 0.
- R7: A data write with auto-advance clear leaves the index unchanged, so a second write to the same register overwrites the same byte.
- R8: All 16 bits of an entry are stored and read back unchanged, including bit 15.
- R9: Reads of either register, and cycles with no write, change neither pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: bit 1 = half, bit 0 = data (1) or pointer (0) |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |

## Verification
The background half is first filled by an auto-advancing sweep of 64 writes. A pointer read after the sweep must show the index wrapped back to 0. Each byte is then read back through pointer reloads with auto-advance off, and every byte is read twice, which shows that reads do not move the pointer.

The object half is then filled with a different pattern, and the background half is swept again. A leak between halves, or a wrong entry offset, shows up as a changed background byte.

Further directed sequences cover three cases:
- Repeated writes without auto-advance.
- Pointer writes with bit 6 set.
- High bytes with bit 7 set, which sets entry bit 15.

These separate a wrong low/high byte choice, a stuck or double step of the index, and a dropped top bit.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned PAL_BYTE_W = 8;
  localparam int unsigned PAL_HALVES = 2;

  typedef enum logic [1:0] {
    SEL_BG_PTR  = 2'b00,
    SEL_BG_DAT  = 2'b01,
    SEL_OBJ_PTR = 2'b10,
    SEL_OBJ_DAT = 2'b11
  } pal_sel_e;
endpackage

// File: rtl/pal_pointer.sv
module pal_pointer #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IDX_W = BYTE_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              adv
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             adv_q, adv_d;
  logic             en;
  logic             unused_fixed_bit;

  assign unused_fixed_bit = wdata[IDX_W];
  assign en = ptr_we | (dat_we & adv_q);

  always_comb begin
    idx_d = idx_q;
    adv_d = adv_q;
    if (ptr_we) begin
      idx_d = wdata[IDX_W-1:0];
      adv_d = wdata[BYTE_W-1];
    end else if (dat_we && adv_q) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      adv_q <= 1'b0;
    end else if (en) begin
      idx_q <= idx_d;
      adv_q <= adv_d;
    end
  end

  assign idx = idx_q;
  assign adv = adv_q;

  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (idx == $past(wdata[IDX_W-1:0])) && (adv == $past(wdata[BYTE_W-1])));
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !ptr_we && adv) |=> idx == $past(idx) + 1'b1);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !ptr_we && !adv) |=> $stable(idx));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_we && !ptr_we) |=> ($stable(idx) && $stable(adv)));
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALVES = 2,
  localparam int unsigned IDX_W = BYTE_W - 2,
  localparam int unsigned ENT_PER_HALF = 2 ** (IDX_W - 1),
  localparam int unsigned ENTRIES = ENT_PER_HALF * HALVES,
  localparam int unsigned ENT_AW = $clog2(ENTRIES),
  localparam int unsigned HALF_W = $clog2(HALVES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [HALF_W-1:0] half,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [2*BYTE_W-1:0] mem [ENTRIES];
  logic [ENT_AW-1:0]   ent;
  logic [2*BYTE_W-1:0] word;

  assign ent = {half, idx[IDX_W-1:1]};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic lane_en;
    assign lane_en = we & (idx[0] == g[0]);
    always_ff @(posedge clk) begin
      if (lane_en) mem[ent][g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  assign word  = mem[ent];
  assign rdata = idx[0] ? word[2*BYTE_W-1:BYTE_W] : word[BYTE_W-1:0];
endmodule

// File: rtl/palette_port.sv
module palette_port
  import pal_pkg::*;
#(
  parameter int unsigned BYTE_W = PAL_BYTE_W,
  localparam int unsigned IDX_W = BYTE_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic [IDX_W-1:0]  idx [PAL_HALVES];
  logic [PAL_HALVES-1:0] adv;
  logic              half;
  logic              is_dat;
  logic [BYTE_W-1:0] store_rd;

  assign half   = bus_sel[1];
  assign is_dat = bus_sel[0];

  for (genvar h = 0; h < PAL_HALVES; h++) begin : g_ptr
    pal_pointer #(.BYTE_W(BYTE_W)) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ptr_we(bus_wr & ~is_dat & (half == h[0])),
      .dat_we(bus_wr &  is_dat & (half == h[0])),
      .wdata (bus_wdata),
      .idx   (idx[h]),
      .adv   (adv[h])
    );
  end

  pal_store #(.BYTE_W(BYTE_W), .HALVES(PAL_HALVES)) i_store (
    .clk  (clk),
    .we   (bus_wr & is_dat),
    .half (half),
    .idx  (idx[half]),
    .wdata(bus_wdata),
    .rdata(store_rd)
  );

  always_comb begin
    if (is_dat) bus_rdata = store_rd;
    else        bus_rdata = {adv[half], 1'b1, idx[half]};
  end

  a_r2_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dat |-> bus_rdata[IDX_W]);
  a_r3_store_back: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_dat && !adv[half]) |=>
      ((bus_sel != $past(bus_sel)) || bus_wr || (bus_rdata == $past(bus_wdata))));
  a_r4_other_half: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> ($past(half) ? $stable(idx[0]) : $stable(idx[1])));
endmodule

// File: tb/test_palette_port.sv
module test_palette_port;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'b00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  palette_port i_palette_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model built from the requirements.
  logic [7:0] m_mem [128];
  logic [5:0] m_idx [2];
  logic       m_adv [2];

  logic [7:0] exp_q [$];
  string      tag_q [$];
  event       sample_ev;

  // Monitor: pops expected items and compares them with the design output.
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic ptr_wr(input int h, input logic [7:0] v);
    @(negedge clk);
    bus_sel = {h[0], 1'b0}; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_idx[h] = v[5:0];
    m_adv[h] = v[7];
  endtask

  task automatic dat_wr(input int h, input logic [7:0] v);
    @(negedge clk);
    bus_sel = {h[0], 1'b1}; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_mem[h*64 + m_idx[h]] = v;
    if (m_adv[h]) m_idx[h] = m_idx[h] + 6'd1;
  endtask

  task automatic rd_ptr(input int h, input string t);
    @(negedge clk);
    bus_sel = {h[0], 1'b0};
    exp_q.push_back({m_adv[h], 1'b1, m_idx[h]});
    tag_q.push_back(t);
    #1 -> sample_ev;
  endtask

  task automatic rd_dat(input int h, input string t);
    @(negedge clk);
    bus_sel = {h[0], 1'b1};
    exp_q.push_back(m_mem[h*64 + m_idx[h]]);
    tag_q.push_back(t);
    #1 -> sample_ev;
  endtask

  task automatic sweep_check(input int h, input string t);
    for (int i = 0; i < 64; i++) begin
      ptr_wr(h, 8'(i));
      rd_dat(h, t);
      rd_dat(h, "R9 data read repeat");
    end
    rd_ptr(h, "R9 pointer after reads");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_idx[0] = 6'd0; m_idx[1] = 6'd0; m_adv[0] = 1'b0; m_adv[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_ptr(0, "R1 background pointer reset");
    rd_ptr(1, "R1 object pointer reset");

    ptr_wr(0, 8'hBF);
    rd_ptr(0, "R2 pointer load with bit6 set");
    ptr_wr(0, 8'h00);
    rd_ptr(0, "R2 pointer load zero");
    rd_ptr(1, "R4 object pointer untouched");

    // R6: auto-advancing fill of background half, wrap 63 -> 0.
    ptr_wr(0, 8'h80);
    for (int i = 0; i < 64; i++) dat_wr(0, 8'(i*37 + 11));
    rd_ptr(0, "R6 index wrapped after sweep");
    sweep_check(0, "R3 R5 background byte readback");

    // R4: object half filled, then background rechecked.
    ptr_wr(1, 8'hC0);
    for (int i = 0; i < 64; i++) dat_wr(1, 8'(~(i*13) + 5));
    rd_ptr(1, "R6 object index wrapped");
    sweep_check(1, "R4 object byte readback");
    sweep_check(0, "R4 background unchanged by object writes");

    // R7: writes without auto-advance overwrite the same byte.
    ptr_wr(0, 8'h05);
    dat_wr(0, 8'h12);
    dat_wr(0, 8'h34);
    rd_ptr(0, "R7 index held");
    rd_dat(0, "R7 last write kept");

    // R8: high byte with bit 7 set (entry bit 15).
    ptr_wr(1, 8'h0B);
    dat_wr(1, 8'hFF);
    rd_dat(1, "R8 high byte all ones");
    ptr_wr(1, 8'h8A);
    dat_wr(1, 8'h00);
    rd_ptr(1, "R6 step from 0A");
    rd_dat(1, "R8 high byte after low write");

    // R5: pointer switch immediately readdresses data port.
    ptr_wr(0, 8'h05);
    rd_dat(0, "R5 readdress after pointer write");
    ptr_wr(0, 8'h3F);
    rd_dat(0, "R5 last background byte");
    rd_ptr(0, "R2 pointer readback 3F");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule